// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the device-side control logic of a byte-wide, sector-erasable flash memory of 512K bytes. It watches a synchronous model of the chip-enable, output-enable and write-enable strobes together with the address and data buses. It decodes two-cycle command sequences and runs program and erase operations for a configurable number of clock cycles. The array itself sits outside the block as a small memory with an asynchronous read port and a clocked write port. The block drives that memory's address, write data and write enable, and takes its read data back.

A host uses it as it would use the chip. It sends a setup byte in one write cycle. The next write cycle is the execute cycle: for a program it carries the target address and data, and for an erase it carries the confirm byte. The host then reads the array until the status bits show that the operation is done. An identification mode returns fixed ID bytes. An external protect flag blocks every command that would change the array.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in read mode. A read cycle (ce_n=0, oe_n=0, we_n=1) returns the array byte at `addr` on `dout`. `dout_oe` is 1 only while ce_n and oe_n are both 0.
- R2: A write of 10h followed by a second write cycle stores that cycle's data at that cycle's address. The store happens PROG_CYC cycles after the second cycle ends, and no other byte changes.
- R3: A write of 20h followed by a write of D0h sets to FFh every byte whose upper bits `addr[ADDR_W-1:8]` match the address of the D0h cycle. Bytes of other sectors keep their values.
- R4: A write of 30h followed by a second write of 30h sets every byte of the array to FFh.
- R5: A write of FFh right after any setup byte (10h, 20h or 30h) cancels the sequence, changes no byte, and returns to read mode.
- R6: After a 20h or 30h setup, any write cycle other than its own execute byte returns to read mode with no operation, and that cycle is not decoded as a new command.
- R7: A write of 90h enters ID mode. Reads at address 0 return BFh, at address 1 return 04h, and at any other address return 00h. A write of FFh (or another accepted command) leaves ID mode.
- R8: While `prot_i` is 1, the setup bytes 10h, 20h and 30h are ignored. 90h and FFh are still accepted.
- R9: A write cycle is the interval with ce_n=0, we_n=0 and oe_n=1. Its address is sampled in its first clock and its data in its last clock.
- R10: Strobe activity with oe_n=0 is never taken as a write cycle.
- R11: While an operation runs, reads return bit 7 as the inverse of the target data's bit 7 (FFh for erase), bit 6 as a flag that flips after every completed read, and bits 5:0 as zero.
- R12: Write cycles that arrive while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address from the host |
| din | input | 8 | Write data from the host |
| prot_i | input | 1 | Protect flag; 1 blocks array-changing commands |
| dout | output | 8 | Read data or status toward the host |
| dout_oe | output | 1 | Output drive enable for `dout` |
| mem_addr | output | ADDR_W | Address to the backing memory |
| mem_wdata | output | 8 | Write data to the backing memory |
| mem_we | output | 1 | Write strobe to the backing memory |
| mem_rdata | input | 8 | Asynchronous read data from the backing memory |

## Verification
The hardest situation to create is a write cycle whose address and data change while the strobes are low. The captured address must come from the first clock of the cycle, and the captured data from the last clock. The bench reaches this case with a program cycle that moves both buses halfway through the low pulse. It then checks that the first address holds the second data byte. A second hard case is a set of command writes that arrive while a program is still running. The bench issues them straight after the execute cycle, which keeps them inside the PROG_CYC window. It then checks that no erase follows and that no other byte changes.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W    = 19,
  parameter int SECT_W    = 8,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              prot_i,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [7:0] C_PROG = 8'h10, C_SERASE = 8'h20, C_CHIP = 8'h30,
                         C_CONF = 8'hD0, C_ID = 8'h90, C_RST = 8'hFF;

  typedef enum logic [2:0] {S_READ, S_ID, S_ESET, S_PSET, S_CSET, S_PROG, S_ERASE, S_SETTLE} st_t;

  st_t st;
  logic wr_act, wr_q, rd_act, rd_q, wr_end, rd_end, busy, tog;
  logic [ADDR_W-1:0] a_lat, tgt_a, ptr, last;
  logic [7:0] d_lat, tgt_d;
  logic [CNT_W-1:0] cnt;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n && we_n;
  assign wr_end = wr_q && !wr_act;
  assign rd_end = rd_q && !rd_act;
  assign busy   = (st == S_PROG) || (st == S_ERASE) || (st == S_SETTLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_READ;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      tog   <= 1'b0;
      a_lat <= '0;
      d_lat <= '0;
      tgt_a <= '0;
      tgt_d <= '0;
      ptr   <= '0;
      last  <= '0;
      cnt   <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) a_lat <= addr;
      if (wr_act) d_lat <= din;
      if (busy && rd_end) tog <= ~tog;
      case (st)
        S_READ, S_ID:
          if (wr_end) begin
            case (d_lat)
              C_PROG:   if (!prot_i) st <= S_PSET;
              C_SERASE: if (!prot_i) st <= S_ESET;
              C_CHIP:   if (!prot_i) st <= S_CSET;
              C_ID:     st <= S_ID;
              C_RST:    st <= S_READ;
              default:  ;
            endcase
          end
        S_PSET:
          if (wr_end) begin
            if (d_lat == C_RST) st <= S_READ;
            else begin
              tgt_a <= a_lat;
              tgt_d <= d_lat;
              cnt   <= CNT_W'(PROG_CYC - 1);
              st    <= S_PROG;
            end
          end
        S_ESET:
          if (wr_end) begin
            if (d_lat == C_CONF) begin
              ptr   <= {a_lat[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
              last  <= {a_lat[ADDR_W-1:SECT_W], {SECT_W{1'b1}}};
              tgt_d <= 8'hFF;
              st    <= S_ERASE;
            end else st <= S_READ;
          end
        S_CSET:
          if (wr_end) begin
            if (d_lat == C_CHIP) begin
              ptr   <= '0;
              last  <= '1;
              tgt_d <= 8'hFF;
              st    <= S_ERASE;
            end else st <= S_READ;
          end
        S_PROG:
          if (cnt == '0) st <= S_READ;
          else cnt <= cnt - 1'b1;
        S_ERASE: begin
          ptr <= ptr + 1'b1;
          if (ptr == last) begin
            cnt <= CNT_W'(ERASE_CYC - 1);
            st  <= S_SETTLE;
          end
        end
        S_SETTLE:
          if (cnt == '0) st <= S_READ;
          else cnt <= cnt - 1'b1;
        default: st <= S_READ;
      endcase
    end
  end

  assign mem_we    = ((st == S_PROG) && (cnt == '0)) || (st == S_ERASE);
  assign mem_wdata = (st == S_PROG) ? tgt_d : 8'hFF;
  assign mem_addr  = (st == S_PROG) ? tgt_a : (st == S_ERASE) ? ptr : addr;
  assign dout_oe   = !ce_n && !oe_n;

  always_comb begin
    if (busy)             dout = {~tgt_d[7], tog, 6'b0};
    else if (st == S_ID)  dout = (addr == '0) ? 8'hBF :
                                 (addr == ADDR_W'(1)) ? 8'h04 : 8'h00;
    else                  dout = mem_rdata;
  end

  assert_tog_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_end) |=> (tog != $past(tog)));
  assert_we_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (st == S_PROG || st == S_ERASE));
  assert_erase_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE) |-> (mem_we && mem_wdata == 8'hFF));
  assert_prot_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && prot_i && wr_end) |=> (st == S_READ || st == S_ID));
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && wr_end) |=> (st == S_SETTLE || st == S_READ));
  assert_read_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |-> !mem_we);
endmodule

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, prot = 1;
  logic [AW-1:0] addr = '0, mem_addr;
  logic [7:0] din = '0, dout, mem_wdata, mem_rdata;
  logic dout_oe, mem_we;
  logic [7:0] mem [0:(1<<AW)-1];

  always #10 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .SECT_W(8), .PROG_CYC(20), .ERASE_CYC(30)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .prot_i(prot), .dout(dout), .dout_oe(dout_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int nvec = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got;
  event smp;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {4'h0, a[11:8]};
  endfunction

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = pat(AW'(i));

  always begin
    @(smp);
    nvec++;
    if (got !== exp_q[0]) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag_q[0], got, exp_q[0]);
    end
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  task automatic direct(input logic [7:0] g, input logic [7:0] e, input string t);
    nvec++;
    if (g !== e) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", t, g, e);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe = 1'b1);
    @(negedge clk); addr = a; din = d; oe_n = oe; ce_n = 0; we_n = 0;
    @(negedge clk); @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    #2 v = dout;
    @(negedge clk); oe_n = 1; ce_n = 1;
  endtask

  task automatic chk(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    logic [7:0] v;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd(a, v);
    got = v;
    -> smp;
    @(negedge clk);
  endtask

  task automatic poll(input logic [AW-1:0] a, input logic b7, input string t);
    logic [7:0] v;
    bit ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(a, v);
      if (v[7] == b7) begin ok = 1; break; end
    end
    direct({7'b0, ok}, 8'd1, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    direct({7'b0, dout_oe}, 8'd0, "R1 oe in reset");
    rst_n = 1;
    @(negedge clk);
    chk(12'h005, pat(12'h005), "R1 read mode");

    // R8: array-changing setups ignored while protected
    wr(12'h000, 8'h10); wr(12'h007, 8'h33);
    chk(12'h007, pat(12'h007), "R8 program blocked");
    wr(12'h000, 8'h20); wr(12'h245, 8'hD0);
    chk(12'h245, pat(12'h245), "R8 erase blocked");

    // R7: ID mode, entered while protected (R8)
    wr(12'h000, 8'h90);
    chk(12'h000, 8'hBF, "R7 id0");
    chk(12'h001, 8'h04, "R7 id1");
    chk(12'h002, 8'h00, "R7 other");
    wr(12'h000, 8'hFF);
    chk(12'h000, pat(12'h000), "R7 exit");
    prot = 0;

    // R2 / R11: program with status reads
    wr(12'h000, 8'h10); wr(12'h123, 8'h3C);
    chk(12'h123, 8'h80, "R11 status first");
    chk(12'h123, 8'hC0, "R11 status toggled");
    poll(12'h123, 1'b0, "R2 done");
    chk(12'h123, 8'h3C, "R2 stored");
    chk(12'h124, pat(12'h124), "R2 neighbour");

    // R3: sector erase
    wr(12'h000, 8'h20); wr(12'h245, 8'hD0);
    rd(12'h245, v);
    direct({v[7], 1'b0, v[5:0]}, 8'h00, "R11 erase status");
    poll(12'h245, 1'b1, "R3 done");
    chk(12'h200, 8'hFF, "R3 low");
    chk(12'h2FF, 8'hFF, "R3 high");
    chk(12'h1FF, pat(12'h1FF), "R3 below");
    chk(12'h300, pat(12'h300), "R3 above");

    // R5: abort by FFh
    wr(12'h000, 8'h20); wr(12'h300, 8'hFF);
    chk(12'h300, pat(12'h300), "R5 erase abort");
    wr(12'h000, 8'h10); wr(12'h400, 8'hFF);
    chk(12'h400, pat(12'h400), "R5 program abort");

    // R6: wrong execute byte
    wr(12'h000, 8'h20); wr(12'h500, 8'h55);
    chk(12'h500, pat(12'h500), "R6 bad confirm");
    wr(12'h000, 8'h30); wr(12'h000, 8'h20); wr(12'h600, 8'hD0);
    chk(12'h600, pat(12'h600), "R6 no redecode");

    // R10: oe low inhibits writes
    wr(12'h000, 8'h10, 1'b0); wr(12'h700, 8'h11, 1'b0);
    chk(12'h700, pat(12'h700), "R10 inhibited");
    wr(12'h701, 8'h22);
    chk(12'h701, pat(12'h701), "R10 no setup");

    // R9: address at start, data at end
    wr(12'h000, 8'h10);
    @(negedge clk); addr = 12'h080; din = 8'h21; ce_n = 0; we_n = 0;
    @(negedge clk); addr = 12'h081; din = 8'h22;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    poll(12'h080, 1'b0, "R9 done");
    chk(12'h080, 8'h22, "R9 latched");
    chk(12'h081, pat(12'h081), "R9 second addr");

    // R12: writes during busy ignored
    wr(12'h000, 8'h10); wr(12'h050, 8'h92);
    wr(12'h000, 8'h20); wr(12'h050, 8'hD0);
    poll(12'h050, 1'b1, "R12 done");
    chk(12'h050, 8'h92, "R12 data");
    chk(12'h051, pat(12'h051), "R12 no erase");

    // R4: chip erase
    wr(12'h000, 8'h30); wr(12'h777, 8'h30);
    poll(12'h000, 1'b1, "R4 done");
    chk(12'h000, 8'hFF, "R4 first");
    chk(12'h123, 8'hFF, "R4 programmed");
    chk(12'hFFF, 8'hFF, "R4 last");
    @(negedge clk); ce_n = 0; #2;
    direct({7'b0, dout_oe}, 8'd0, "R1 oe high");
    @(negedge clk); ce_n = 1;

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule